// File: doc/BRIEF.md
# Multi-Bit Error Read Retry Controller

This block sits beside a DRAM bank scheduler and watches read completions. For every bank it remembers the reads that are in flight, keyed by transaction ID, together with the address and a privilege flag that marks a request as user-level or system-level. When a completion reports an uncorrectable error and the word is not marked poisoned, the block does three things. It answers upstream with a provisional reply carrying a squash bit, so the requester discards it. It asks the bank arbiter to hold all other traffic to that bank. Once the bank's turnaround time has passed, it issues the same read again.

Retries continue until a read comes back clean or corrected, or until a configured retry limit is used up. A clean retry returns its data under the original transaction ID with the squash bit clear. When the limit is exhausted, the block returns a final error reply and writes a persistent-error log record. It then raises an exception on one of two lines, chosen by the privilege flag. Poisoned words bypass all of this and return an error at once. ECC decoding happens upstream; the block sees only a status code and a poison flag.

Top module: `mbe_retry_ctrl`

## Requirements
- R1: After reset, no reply, retry, log record, exception or bank hold is asserted.
- R2: A completion whose transaction ID is in flight on its bank, with status 0 (clean) or 1 (corrected) and poison low, produces a reply one cycle later with that ID and data, squash low and error low, and frees the tracking slot.
- R3: A completion with status 2 or 3 (uncorrectable) and poison low, whose retries used so far are below the limit, produces a reply one cycle later with squash high and error low. The bank's hold line rises in that same cycle and stays high until the retry is issued. The retry, carrying the same bank, ID and address, is presented BANK_GAP cycles after that reply.
- R4: A completion with poison high produces a reply with error and poison high and squash low, with no retry, no hold, no log record and no exception.
- R5: A retried read that later completes clean returns its data under the original ID with squash and error low.
- R6: With limit n greater than zero, the first n uncorrectable completions of a read are squashed. The next one produces an error reply with squash low, and in the same cycle a log record carrying the bank, ID, address, privilege flag and attempt count n.
- R7: With a limit of zero, the first uncorrectable completion is reported as a final error at once, with a log record and no retry.
- R8: A final error raises exc_os for a system request (flag 1) and exc_app for a user request (flag 0), never both.
- R9: Holds are per bank: a pending retry on one bank leaves the other banks' holds low, and reads on other banks complete normally meanwhile. When several banks are ready, the lowest-numbered bank is retried first.
- R10: A completion whose ID is not in flight on its bank produces no reply; a read issued to a bank while its hold is high is not tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_retry_limit | input | CNT_W | Maximum number of retries per read |
| iss_vld | input | 1 | A read has been issued to a bank |
| iss_bank | input | BANK_W | Bank of the issued read |
| iss_tid | input | TID_W | Transaction ID of the issued read |
| iss_addr | input | ADDR_W | Address of the issued read |
| iss_sys | input | 1 | Privilege flag, 1 for system, 0 for user |
| cpl_vld | input | 1 | A read completion is present |
| cpl_bank | input | BANK_W | Bank of the completion |
| cpl_tid | input | TID_W | Transaction ID of the completion |
| cpl_status | input | 2 | 0 clean, 1 corrected, 2 or 3 uncorrectable |
| cpl_poison | input | 1 | Word is marked poisoned |
| cpl_data | input | DATA_W | Read data |
| bank_hold | output | NUM_BANKS | Per bank: block other requests, a retry is pending |
| retry_vld | output | 1 | Retry read is issued this cycle |
| retry_bank | output | BANK_W | Bank of the retry |
| retry_tid | output | TID_W | Transaction ID of the retry |
| retry_addr | output | ADDR_W | Address of the retry |
| rsp_vld | output | 1 | Reply valid |
| rsp_tid | output | TID_W | Reply transaction ID |
| rsp_data | output | DATA_W | Reply data |
| rsp_squash | output | 1 | Provisional reply, to be discarded |
| rsp_err | output | 1 | Error reply |
| rsp_poison | output | 1 | Error reply for a poisoned word |
| log_vld | output | 1 | Persistent-error log record valid |
| log_bank | output | BANK_W | Logged bank |
| log_tid | output | TID_W | Logged transaction ID |
| log_addr | output | ADDR_W | Logged address |
| log_sys | output | 1 | Logged privilege flag |
| log_attempts | output | CNT_W | Retries performed before giving up |
| exc_app | output | 1 | Exception for a user-level failure |
| exc_os | output | 1 | Exception for a system-level failure |

## Verification
The bench builds the block with four banks, two slots per bank, 4-bit IDs, a 3-bit retry count and a bank gap of two cycles. It sweeps the retry limit from 0 to 3. For each limit it tries every number of consecutive failing reads from zero up to one past the limit, so the squash sequence, success on every possible retry, the exhausted-limit path and the zero-limit case are all covered. Bank, privilege flag and the two uncorrectable codes rotate across the sweep. With small IDs and a short gap, the retry latency is checked cycle-exactly. Directed cases add poisoned words, a clean read on one bank while another bank is held, a read issued into a held bank, and stale or wrong-bank completions.

// File: rtl/mbe_retry_pkg.sv
package mbe_retry_pkg;

  localparam int CNT_MAX_W = 8;

  typedef enum logic [1:0] {
    RD_CLEAN  = 2'd0,
    RD_FIXED  = 2'd1,
    RD_UNCORR = 2'd2,
    RD_RSVD   = 2'd3
  } rd_status_e;

  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_RETRY = 2'd2
  } slot_e;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_DELIVER = 3'd1,
    ACT_POISON  = 3'd2,
    ACT_RETRY   = 3'd3,
    ACT_FAIL    = 3'd4
  } cpl_act_e;

  // Both upper codes count as uncorrectable.
  function automatic logic status_uncorr(input logic [1:0] st);
    return st[1];
  endfunction

  // Outcome of a completion, given the tracking lookup and the retry budget.
  function automatic cpl_act_e classify(input logic hit,
                                        input logic [1:0] st,
                                        input logic poison,
                                        input logic [CNT_MAX_W-1:0] used,
                                        input logic [CNT_MAX_W-1:0] limit);
    if (!hit) return ACT_NONE;
    if (poison) return ACT_POISON;
    if (!status_uncorr(st)) return ACT_DELIVER;
    if (used < limit) return ACT_RETRY;
    return ACT_FAIL;
  endfunction

endpackage

// File: rtl/mbe_bank_tracker.sv
module mbe_bank_tracker
  import mbe_retry_pkg::*;
#(
  parameter int SLOTS    = 2,
  parameter int TID_W    = 4,
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 3,
  parameter int BANK_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [TID_W-1:0]  alloc_tid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_sys,
  input  logic              cpl_vld,
  input  logic [TID_W-1:0]  cpl_tid,
  input  logic [1:0]        cpl_status,
  input  logic              cpl_poison,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              grant,
  output cpl_act_e          cpl_act,
  output logic [ADDR_W-1:0] hit_addr,
  output logic              hit_sys,
  output logic [CNT_W-1:0]  hit_used,
  output logic              retry_rdy,
  output logic [TID_W-1:0]  retry_tid,
  output logic [ADDR_W-1:0] retry_addr,
  output logic              hold
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int TMR_W = $clog2(BANK_GAP + 2);
  localparam logic [TMR_W-1:0] GAP_LOAD = TMR_W'(BANK_GAP);

  slot_e             st_q   [SLOTS];
  logic [TID_W-1:0]  tid_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic              sys_q  [SLOTS];
  logic [CNT_W-1:0]  used_q [SLOTS];
  logic [TMR_W-1:0]  tmr_q;

  // Named internal events.
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             free_ok;
  logic [IDX_W-1:0] free_idx;
  logic             any_retry;
  logic [IDX_W-1:0] rty_idx;
  logic             alloc_take;
  logic             take_grant;
  logic             bank_idle;

  // Lowest-index matches win in each search.
  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_ok = 1'b0; free_idx = '0;
    any_retry = 1'b0; rty_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (st_q[i] == SLOT_BUSY && tid_q[i] == cpl_tid) begin
        hit = cpl_vld;
        hit_idx = IDX_W'(i);
      end
      if (st_q[i] == SLOT_FREE) begin
        free_ok = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (st_q[i] == SLOT_RETRY) begin
        any_retry = 1'b1;
        rty_idx = IDX_W'(i);
      end
    end
  end

  assign cpl_act    = classify(hit, cpl_status, cpl_poison,
                               CNT_MAX_W'(used_q[hit_idx]), CNT_MAX_W'(cfg_limit));
  assign hit_addr   = addr_q[hit_idx];
  assign hit_sys    = sys_q[hit_idx];
  assign hit_used   = used_q[hit_idx];
  assign bank_idle  = (tmr_q == '0);
  assign hold       = any_retry;
  assign retry_rdy  = any_retry && bank_idle;
  assign retry_tid  = tid_q[rty_idx];
  assign retry_addr = addr_q[rty_idx];
  // A held bank accepts no new tracking: the retry must be its next access.
  assign alloc_take = alloc_vld && free_ok && !any_retry;
  assign take_grant = grant && retry_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        st_q[i]   <= SLOT_FREE;
        tid_q[i]  <= '0;
        addr_q[i] <= '0;
        sys_q[i]  <= 1'b0;
        used_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (alloc_take && free_idx == IDX_W'(i)) begin
          st_q[i]   <= SLOT_BUSY;
          tid_q[i]  <= alloc_tid;
          addr_q[i] <= alloc_addr;
          sys_q[i]  <= alloc_sys;
          used_q[i] <= '0;
        end else if (hit && hit_idx == IDX_W'(i)) begin
          if (cpl_act == ACT_RETRY) begin
            st_q[i]   <= SLOT_RETRY;
            used_q[i] <= used_q[i] + CNT_W'(1);
          end else begin
            st_q[i] <= SLOT_FREE;
          end
        end else if (take_grant && rty_idx == IDX_W'(i)) begin
          st_q[i] <= SLOT_BUSY;
        end
      end
    end
  end

  // Bank turnaround timer: restarts on every access to the bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (alloc_take || cpl_act == ACT_RETRY || take_grant) begin
      tmr_q <= GAP_LOAD;
    end else if (!bank_idle) begin
      tmr_q <= tmr_q - TMR_W'(1);
    end
  end

  // R3: a pending retry keeps the bank held until it is issued.
  p_hold_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !take_grant |=> hold);

  // R3: the retry never goes out in the cycle the hold first appears.
  p_retry_waits_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !retry_rdy);

  // R10: a held bank's busy count cannot grow except through a retry or a completion.
  p_held_no_growth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !hit |=> $countones({st_q[0] == SLOT_FREE, st_q[SLOTS-1] == SLOT_FREE})
                     >= $past($countones({st_q[0] == SLOT_FREE, st_q[SLOTS-1] == SLOT_FREE})));

endmodule

// File: rtl/mbe_retry_arb.sv
module mbe_retry_arb #(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] req,
  output logic [NB-1:0] grant,
  output logic [BW-1:0] grant_idx
);

  // Fixed priority, lowest bank first.
  always_comb begin
    grant = '0;
    grant_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        grant_idx = BW'(i);
      end
    end
  end

  // R9: at most one retry per cycle.
  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9: a grant exists whenever any bank asks, and no lower bank is passed over.
  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|(grant & req)) && ((req & (grant - NB'(1))) == '0));

endmodule

// File: rtl/mbe_retry_ctrl.sv
module mbe_retry_ctrl
  import mbe_retry_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int SLOTS     = 2,
  parameter int TID_W     = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 3,
  parameter int BANK_GAP  = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_retry_limit,
  input  logic                 iss_vld,
  input  logic [BANK_W-1:0]    iss_bank,
  input  logic [TID_W-1:0]     iss_tid,
  input  logic [ADDR_W-1:0]    iss_addr,
  input  logic                 iss_sys,
  input  logic                 cpl_vld,
  input  logic [BANK_W-1:0]    cpl_bank,
  input  logic [TID_W-1:0]     cpl_tid,
  input  logic [1:0]           cpl_status,
  input  logic                 cpl_poison,
  input  logic [DATA_W-1:0]    cpl_data,
  output logic [NUM_BANKS-1:0] bank_hold,
  output logic                 retry_vld,
  output logic [BANK_W-1:0]    retry_bank,
  output logic [TID_W-1:0]     retry_tid,
  output logic [ADDR_W-1:0]    retry_addr,
  output logic                 rsp_vld,
  output logic [TID_W-1:0]     rsp_tid,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 rsp_squash,
  output logic                 rsp_err,
  output logic                 rsp_poison,
  output logic                 log_vld,
  output logic [BANK_W-1:0]    log_bank,
  output logic [TID_W-1:0]     log_tid,
  output logic [ADDR_W-1:0]    log_addr,
  output logic                 log_sys,
  output logic [CNT_W-1:0]     log_attempts,
  output logic                 exc_app,
  output logic                 exc_os
);

  logic [NUM_BANKS-1:0][2:0]        act_v;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] hadr_v;
  logic [NUM_BANKS-1:0]             hsys_v;
  logic [NUM_BANKS-1:0][CNT_W-1:0]  hused_v;
  logic [NUM_BANKS-1:0]             rdy_v;
  logic [NUM_BANKS-1:0][TID_W-1:0]  rtid_v;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] radr_v;
  logic [NUM_BANKS-1:0]             grant_v;
  logic [BANK_W-1:0]                grant_idx;
  cpl_act_e                         sel_act;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cpl_act_e bank_act;
    mbe_bank_tracker #(
      .SLOTS(SLOTS), .TID_W(TID_W), .ADDR_W(ADDR_W),
      .CNT_W(CNT_W), .BANK_GAP(BANK_GAP)
    ) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_vld  (iss_vld && iss_bank == BANK_W'(b)),
      .alloc_tid  (iss_tid),
      .alloc_addr (iss_addr),
      .alloc_sys  (iss_sys),
      .cpl_vld    (cpl_vld && cpl_bank == BANK_W'(b)),
      .cpl_tid    (cpl_tid),
      .cpl_status (cpl_status),
      .cpl_poison (cpl_poison),
      .cfg_limit  (cfg_retry_limit),
      .grant      (grant_v[b]),
      .cpl_act    (bank_act),
      .hit_addr   (hadr_v[b]),
      .hit_sys    (hsys_v[b]),
      .hit_used   (hused_v[b]),
      .retry_rdy  (rdy_v[b]),
      .retry_tid  (rtid_v[b]),
      .retry_addr (radr_v[b]),
      .hold       (bank_hold[b])
    );
    assign act_v[b] = bank_act;
  end

  mbe_retry_arb #(.NB(NUM_BANKS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (rdy_v),
    .grant     (grant_v),
    .grant_idx (grant_idx)
  );

  assign retry_vld  = |grant_v;
  assign retry_bank = grant_idx;
  assign retry_tid  = rtid_v[grant_idx];
  assign retry_addr = radr_v[grant_idx];

  assign sel_act = cpl_act_e'(act_v[cpl_bank]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld      <= 1'b0;
      rsp_tid      <= '0;
      rsp_data     <= '0;
      rsp_squash   <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_poison   <= 1'b0;
      log_vld      <= 1'b0;
      log_bank     <= '0;
      log_tid      <= '0;
      log_addr     <= '0;
      log_sys      <= 1'b0;
      log_attempts <= '0;
      exc_app      <= 1'b0;
      exc_os       <= 1'b0;
    end else begin
      rsp_vld    <= (sel_act != ACT_NONE);
      rsp_tid    <= cpl_tid;
      rsp_data   <= cpl_data;
      rsp_squash <= (sel_act == ACT_RETRY);
      rsp_err    <= (sel_act == ACT_POISON) || (sel_act == ACT_FAIL);
      rsp_poison <= (sel_act == ACT_POISON);
      log_vld    <= (sel_act == ACT_FAIL);
      exc_app    <= (sel_act == ACT_FAIL) && !hsys_v[cpl_bank];
      exc_os     <= (sel_act == ACT_FAIL) && hsys_v[cpl_bank];
      if (sel_act == ACT_FAIL) begin
        log_bank     <= cpl_bank;
        log_tid      <= cpl_tid;
        log_addr     <= hadr_v[cpl_bank];
        log_sys      <= hsys_v[cpl_bank];
        log_attempts <= hused_v[cpl_bank];
      end
    end
  end

  // R3: a provisional reply is never an error reply.
  p_squash_not_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_squash |-> !rsp_err && !rsp_poison);

  // R3: a retry only leaves a bank that is being held for it.
  p_retry_from_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_vld |-> bank_hold[retry_bank]);

  // R4: poisoned replies never reach the persistent log.
  p_poison_unlogged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_poison |-> !log_vld && !exc_app && !exc_os);

  // R6: a log record travels with a final, unsquashed error reply.
  p_log_with_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    log_vld |-> rsp_vld && rsp_err && !rsp_squash && !rsp_poison);

  // R6: the logged count equals the limit in force at the completion.
  p_log_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    log_vld |-> log_attempts == $past(cfg_retry_limit));

  // R8: exactly one exception line, matching the logged privilege flag.
  p_exc_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    log_vld |-> (exc_os == log_sys) && (exc_app == !log_sys));

  p_exc_only_on_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !log_vld |-> !exc_app && !exc_os);

endmodule

// File: tb/mbe_retry_ctrl_bench.sv
module mbe_retry_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BW = 2;
  localparam int TW = 4;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CW = 3;
  localparam int GAP = 2;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_retry_limit = '0;
  logic          iss_vld = 1'b0;
  logic [BW-1:0] iss_bank = '0;
  logic [TW-1:0] iss_tid = '0;
  logic [AW-1:0] iss_addr = '0;
  logic          iss_sys = 1'b0;
  logic          cpl_vld = 1'b0;
  logic [BW-1:0] cpl_bank = '0;
  logic [TW-1:0] cpl_tid = '0;
  logic [1:0]    cpl_status = '0;
  logic          cpl_poison = 1'b0;
  logic [DW-1:0] cpl_data = '0;
  logic [NB-1:0] bank_hold;
  logic          retry_vld;
  logic [BW-1:0] retry_bank;
  logic [TW-1:0] retry_tid;
  logic [AW-1:0] retry_addr;
  logic          rsp_vld;
  logic [TW-1:0] rsp_tid;
  logic [DW-1:0] rsp_data;
  logic          rsp_squash, rsp_err, rsp_poison;
  logic          log_vld;
  logic [BW-1:0] log_bank;
  logic [TW-1:0] log_tid;
  logic [AW-1:0] log_addr;
  logic          log_sys;
  logic [CW-1:0] log_attempts;
  logic          exc_app, exc_os;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbe_retry_ctrl #(
    .NUM_BANKS(NB), .SLOTS(2), .TID_W(TW), .ADDR_W(AW),
    .DATA_W(DW), .CNT_W(CW), .BANK_GAP(GAP)
  ) u_mbe_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_retry_limit(cfg_retry_limit),
    .iss_vld(iss_vld), .iss_bank(iss_bank), .iss_tid(iss_tid),
    .iss_addr(iss_addr), .iss_sys(iss_sys),
    .cpl_vld(cpl_vld), .cpl_bank(cpl_bank), .cpl_tid(cpl_tid),
    .cpl_status(cpl_status), .cpl_poison(cpl_poison), .cpl_data(cpl_data),
    .bank_hold(bank_hold), .retry_vld(retry_vld), .retry_bank(retry_bank),
    .retry_tid(retry_tid), .retry_addr(retry_addr),
    .rsp_vld(rsp_vld), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
    .rsp_squash(rsp_squash), .rsp_err(rsp_err), .rsp_poison(rsp_poison),
    .log_vld(log_vld), .log_bank(log_bank), .log_tid(log_tid),
    .log_addr(log_addr), .log_sys(log_sys), .log_attempts(log_attempts),
    .exc_app(exc_app), .exc_os(exc_os)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic issue(input int b, input int tid, input int addr, input bit sys);
    iss_bank = BW'(b); iss_tid = TW'(tid); iss_addr = AW'(addr); iss_sys = sys;
    iss_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    iss_vld = 1'b0;
  endtask

  task automatic complete(input int b, input int tid, input int st, input bit poi,
                          input logic [DW-1:0] data);
    cpl_bank = BW'(b); cpl_tid = TW'(tid); cpl_status = 2'(st);
    cpl_poison = poi; cpl_data = data; cpl_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    cpl_vld = 1'b0; cpl_poison = 1'b0;
  endtask

  task automatic wait_retry(output int gap);
    gap = 0;
    while (!retry_vld && gap < 30) begin
      @(negedge clk);
      gap++;
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int tid, input int attempt);
    return DW'(32'hA5C30000) ^ DW'(tid << 8) ^ DW'(attempt * 3 + 1);
  endfunction

  // One read against limit n that fails f times before reading clean.
  task automatic run_case(input int n, input int f, input int b, input bit sys);
    int tid, addr, gap;
    tid = (n * 5 + f) % 16;
    addr = n * 37 + f * 11 + b;
    cfg_retry_limit = CW'(n);
    issue(b, tid, addr, sys);
    for (int a = 0; a < 16; a++) begin
      if (a < f) begin
        complete(b, tid, (a % 2 == 0) ? 2 : 3, 1'b0, pattern(tid, a));
        if (a < n) begin
          chk(rsp_vld && rsp_squash && !rsp_err && rsp_tid == TW'(tid), "R3 squash reply",
              {rsp_vld, rsp_squash, rsp_err}, 3'b110);
          chk(bank_hold == NB'(1 << b), "R3 hold raised", bank_hold, NB'(1 << b));
          chk(!log_vld, "R3 no log on retry", log_vld, 0);
          wait_retry(gap);
          chk(gap == GAP, "R3 retry latency", gap, GAP);
          chk(retry_vld && retry_bank == BW'(b) && retry_tid == TW'(tid)
              && retry_addr == AW'(addr), "R3 retry fields",
              {retry_bank, retry_tid, retry_addr}, {BW'(b), TW'(tid), AW'(addr)});
          chk(bank_hold[b], "R3 hold until issue", bank_hold, NB'(1 << b));
          @(negedge clk);
          chk(bank_hold == '0, "R3 hold released", bank_hold, 0);
        end else begin
          chk(rsp_vld && rsp_err && !rsp_squash && !rsp_poison && rsp_tid == TW'(tid),
              (n == 0) ? "R7 immediate final error" : "R6 final error",
              {rsp_vld, rsp_err, rsp_squash, rsp_poison}, 4'b1100);
          chk(log_vld && log_bank == BW'(b) && log_tid == TW'(tid) && log_addr == AW'(addr)
              && log_sys == sys, "R6 log record",
              {log_vld, log_bank, log_tid, log_addr}, {1'b1, BW'(b), TW'(tid), AW'(addr)});
          chk(log_attempts == CW'(n), "R6 logged attempts", log_attempts, n);
          chk(exc_os == sys && exc_app == !sys, "R8 exception routing",
              {exc_os, exc_app}, {sys, !sys});
          @(negedge clk);
          chk(!rsp_vld && !retry_vld && bank_hold == '0, "R7 no further activity",
              {rsp_vld, retry_vld}, 0);
          break;
        end
      end else begin
        complete(b, tid, a % 2, 1'b0, pattern(tid, a));
        chk(rsp_vld && !rsp_squash && !rsp_err && rsp_tid == TW'(tid)
            && rsp_data == pattern(tid, a), (a == 0) ? "R2 clean reply" : "R5 retry success",
            {rsp_vld, rsp_squash, rsp_err, rsp_data}, {3'b100, pattern(tid, a)});
        chk(!log_vld && !exc_app && !exc_os, "R5 no log on success", log_vld, 0);
        @(negedge clk);
        chk(!rsp_vld, "R5 single reply", rsp_vld, 0);
        break;
      end
    end
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_vld && !retry_vld && !log_vld && !exc_app && !exc_os && bank_hold == '0,
        "R1 reset state", {rsp_vld, retry_vld, log_vld, bank_hold}, 0);

    // Sweep every limit and every failure count up to one past it.
    for (int n = 0; n <= 3; n++) begin
      for (int f = 0; f <= n + 1; f++) begin
        run_case(n, f, (n + f) % NB, bit'(f % 2));
      end
    end

    // R4: poisoned word.
    cfg_retry_limit = CW'(2);
    issue(1, 9, 100, 1'b1);
    complete(1, 9, 2, 1'b1, pattern(9, 0));
    chk(rsp_vld && rsp_err && rsp_poison && !rsp_squash && rsp_tid == TW'(9),
        "R4 poison reply", {rsp_vld, rsp_err, rsp_poison, rsp_squash}, 4'b1110);
    chk(!log_vld && !exc_app && !exc_os && bank_hold == '0, "R4 no log no hold",
        {log_vld, bank_hold}, 0);
    begin
      bit seen = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (retry_vld || bank_hold != '0) seen = 1'b1;
      end
      chk(!seen, "R4 never retried", seen, 0);
    end

    // R9 / R10: per-bank hold and an ignored issue into a held bank.
    cfg_retry_limit = CW'(1);
    issue(2, 3, 200, 1'b0);
    issue(0, 4, 300, 1'b0);
    complete(2, 3, 2, 1'b0, pattern(3, 0));
    chk(bank_hold == 4'b0100, "R9 only bank 2 held", bank_hold, 4'b0100);
    issue(2, 7, 210, 1'b0);
    complete(0, 4, 0, 1'b0, pattern(4, 0));
    chk(rsp_vld && !rsp_squash && !rsp_err && rsp_tid == TW'(4), "R9 other bank completes",
        {rsp_vld, rsp_tid}, {1'b1, TW'(4)});
    wait_retry(gap);
    chk(retry_vld && retry_bank == BW'(2) && retry_tid == TW'(3), "R9 held bank retried",
        {retry_bank, retry_tid}, {BW'(2), TW'(3)});
    @(negedge clk);
    complete(2, 7, 0, 1'b0, pattern(7, 0));
    chk(!rsp_vld, "R10 held-bank issue untracked", rsp_vld, 0);
    complete(1, 3, 0, 1'b0, pattern(3, 1));
    chk(!rsp_vld, "R10 wrong bank ignored", rsp_vld, 0);
    complete(2, 3, 1, 1'b0, pattern(3, 1));
    chk(rsp_vld && !rsp_squash && !rsp_err && rsp_data == pattern(3, 1), "R5 corrected retry",
        rsp_data, pattern(3, 1));
    complete(0, 4, 0, 1'b0, pattern(4, 1));
    chk(!rsp_vld, "R10 freed slot ignored", rsp_vld, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule